// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the programmed base address registers of a configuration-space function into decoded address windows, and claims incoming transactions against them. Each clock it reads the command register, a set of general base registers (each with a byte size and a space type, I/O or memory) and one expansion-ROM register. For each region it decides whether the window is legally mapped and, if so, where it starts and ends.

The decoded windows are held in registers. Transactions are matched against these held windows: a request names an address and a space, and one cycle later the block reports whether a region claims it, and which one. When a region's mapped state or base moves, a one-cycle flag marks that region so that downstream routing can refresh its view.

Regions are numbered 0 to NUM_BARS-1 for the general registers; the ROM region takes index NUM_BARS.

Top module: `bar_window_decoder`

## Requirements
- R1: Command register bit 0 enables I/O regions and bit 1 enables memory regions (general memory registers and the ROM region); a region whose space is disabled is unmapped.
- R2: The ROM region is mapped only when bit 0 of its own register is set, in addition to the memory enable.
- R3: A region's decoded base is its register value with the low log2(size) bits cleared, and its end address is base plus size minus one.
- R4: An I/O region is unmapped when its decoded base is zero, when its end is not above its base, or when its end is 0x10000 or higher.
- R5: A memory region (including ROM) is unmapped when its decoded base is zero, when its end is not above its base, or when its end is 0xFFFFFFFF.
- R6: A region whose size is zero is never mapped and never claims an address.
- R7: A request with txn_valid high is claimed by a region when that region is mapped, its space matches txn_is_io, and base <= address <= end (both bounds included); hit_valid and hit_idx show the result on the clock after the request, and hit_idx is 0 when nothing is claimed.
- R8: When several mapped regions claim the same address, the lowest region index is reported.
- R9: map_valid and map_base show each region's decoded state one clock after the inputs are presented; an unmapped region shows a base of zero.
- R10: map_changed pulses for exactly one clock on a region whose mapped flag or base differs from its previously held value, and is low otherwise.
- R11: After reset every region is unmapped with base zero, and hit_valid and map_changed are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reg | input | 16 | Command register (bit 0 I/O enable, bit 1 memory enable) |
| bar_raw | input | NUM_BARS*32 | General base register values, region i at bits [32i+31:32i] |
| bar_size | input | NUM_BARS*32 | Byte size of each general region, power of two or zero |
| bar_is_io | input | NUM_BARS | Space type per general region, 1 for I/O |
| rom_raw | input | 32 | Expansion ROM register, bit 0 is its enable |
| rom_size | input | 32 | Byte size of the ROM region |
| txn_valid | input | 1 | Request present this cycle |
| txn_is_io | input | 1 | Request targets I/O space when high, memory when low |
| txn_addr | input | 32 | Request address |
| map_valid | output | NUM_BARS+1 | Held mapped flag per region |
| map_base | output | (NUM_BARS+1)*32 | Held decoded base per region |
| map_changed | output | NUM_BARS+1 | One-cycle flag per region whose mapping moved |
| hit_valid | output | 1 | A region claimed the previous request |
| hit_idx | output | $clog2(NUM_BARS+1) | Index of the claiming region |

## Verification
The checker watches on every cycle that a disabled I/O space or a cleared ROM enable leaves those regions unmapped, that a claim only follows a request and only names a region that was mapped, that the change flags rise exactly when the held mapping moves, and that reset clears the state. The window arithmetic itself (masking, inclusive bounds, the I/O ceiling, the all-ones memory end, zero-size and size-one regions) and the lowest-index priority among overlapping windows are shown only by the bench's scenarios, which compare claims and held bases against values worked out from the rules.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam int ADDR_W      = 32;
    localparam int CMD_W       = 16;
    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;
    localparam int ROM_EN_BIT  = 0;

    localparam logic [ADDR_W-1:0] IO_SPACE_TOP = 32'h0001_0000;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t base;
        addr_t last;
    } region_t;

    function automatic logic addr_inside(region_t r, addr_t a);
        return r.valid && (a >= r.base) && (a <= r.last);
    endfunction

endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval
    import bar_dec_pkg::*;
(
    input  addr_t   raw,
    input  addr_t   size,
    input  logic    is_io,
    input  logic    is_rom,
    input  logic    io_en,
    input  logic    mem_en,
    output region_t region
);

    addr_t masked;
    addr_t end_addr;
    logic  en_ok;
    logic  bounds_ok;
    logic  ok;

    always_comb begin
        masked   = raw & ~(size - addr_t'(1));
        end_addr = masked + size - addr_t'(1);
        en_ok    = is_io ? io_en : (mem_en && (!is_rom || raw[ROM_EN_BIT]));
        bounds_ok = (masked != '0) && (end_addr > masked) &&
                    (is_io ? (end_addr < IO_SPACE_TOP) : (end_addr != '1));
        ok = (size != '0) && en_ok && bounds_ok;
        region.valid = ok;
        region.base  = ok ? masked   : '0;
        region.last  = ok ? end_addr : '0;
    end

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
    import bar_dec_pkg::*;
#(
    parameter int NREG  = 7,
    parameter int IDX_W = $clog2(NREG)
) (
    input  region_t          regions [NREG],
    input  logic [NREG-1:0]  reg_is_io,
    input  logic             req,
    input  logic             req_is_io,
    input  addr_t            req_addr,
    output logic             found,
    output logic [IDX_W-1:0] found_idx
);

    logic [NREG-1:0] claim;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_claim
            assign claim[g] = req && (reg_is_io[g] == req_is_io) &&
                              addr_inside(regions[g], req_addr);
        end
    endgenerate

    // scan from the top so the lowest claiming index is the one kept
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (claim[i]) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int NUM_BARS = 6,
    localparam int NREG    = NUM_BARS + 1,
    localparam int IDX_W   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CMD_W-1:0]         cmd_reg,
    input  logic [NUM_BARS*32-1:0]   bar_raw,
    input  logic [NUM_BARS*32-1:0]   bar_size,
    input  logic [NUM_BARS-1:0]      bar_is_io,
    input  logic [31:0]              rom_raw,
    input  logic [31:0]              rom_size,
    input  logic                     txn_valid,
    input  logic                     txn_is_io,
    input  logic [31:0]              txn_addr,
    output logic [NREG-1:0]          map_valid,
    output logic [NREG*32-1:0]       map_base,
    output logic [NREG-1:0]          map_changed,
    output logic                     hit_valid,
    output logic [IDX_W-1:0]         hit_idx
);

    region_t         fresh   [NREG];
    region_t         held    [NREG];
    logic [NREG-1:0] fresh_io;
    logic [NREG-1:0] held_io;
    logic            sel_found;
    logic [IDX_W-1:0] sel_idx;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_region
            if (g < NUM_BARS) begin : g_bar
                assign fresh_io[g] = bar_is_io[g];
                bar_region_eval u_eval (
                    .raw    (bar_raw[g*32 +: 32]),
                    .size   (bar_size[g*32 +: 32]),
                    .is_io  (bar_is_io[g]),
                    .is_rom (1'b0),
                    .io_en  (cmd_reg[CMD_IO_BIT]),
                    .mem_en (cmd_reg[CMD_MEM_BIT]),
                    .region (fresh[g])
                );
            end else begin : g_rom
                assign fresh_io[g] = 1'b0;
                bar_region_eval u_eval (
                    .raw    (rom_raw),
                    .size   (rom_size),
                    .is_io  (1'b0),
                    .is_rom (1'b1),
                    .io_en  (cmd_reg[CMD_IO_BIT]),
                    .mem_en (cmd_reg[CMD_MEM_BIT]),
                    .region (fresh[g])
                );
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    held[g]        <= '0;
                    map_changed[g] <= 1'b0;
                end else begin
                    held[g]        <= fresh[g];
                    map_changed[g] <= (fresh[g].valid != held[g].valid) ||
                                      (fresh[g].base  != held[g].base);
                end
            end

            assign map_valid[g]         = held[g].valid;
            assign map_base[g*32 +: 32] = held[g].base;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held_io <= '0;
        end else begin
            held_io <= fresh_io;
        end
    end

    bar_hit_select #(.NREG(NREG), .IDX_W(IDX_W)) u_select (
        .regions   (held),
        .reg_is_io (held_io),
        .req       (txn_valid),
        .req_is_io (txn_is_io),
        .req_addr  (txn_addr),
        .found     (sel_found),
        .found_idx (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= 1'b0;
            hit_idx   <= '0;
        end else begin
            hit_valid <= sel_found;
            hit_idx   <= sel_idx;
        end
    end

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
    parameter int NUM_BARS = 6,
    localparam int NREG    = NUM_BARS + 1,
    localparam int IDX_W   = $clog2(NREG)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [15:0]          cmd_reg,
    input logic [NUM_BARS-1:0]  bar_is_io,
    input logic [31:0]          rom_raw,
    input logic                 txn_valid,
    input logic [NREG-1:0]      map_valid,
    input logic [NREG*32-1:0]   map_base,
    input logic [NREG-1:0]      map_changed,
    input logic                 hit_valid,
    input logic [IDX_W-1:0]     hit_idx
);

    logic [NREG-1:0] io_mask;
    assign io_mask = {1'b0, bar_is_io};

    // R1: I/O space disabled on the previous edge leaves no I/O region mapped
    a_r1_io_disabled_unmapped: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_reg[0]) |-> ((map_valid & $past(io_mask)) == '0));

    // R1: memory space disabled leaves no memory region mapped
    a_r1_mem_disabled_unmapped: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_reg[1]) |-> ((map_valid & ~$past(io_mask)) == '0));

    // R2: ROM enable bit clear keeps the ROM region unmapped
    a_r2_rom_enable: assert property (@(posedge clk) disable iff (rst)
        !$past(rom_raw[0]) |-> !map_valid[NUM_BARS]);

    // R7: a claim only follows a request
    a_r7_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(txn_valid));

    // R7: the claiming region was mapped when the request was sampled
    a_r7_hit_region_mapped: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> ((($past(map_valid) >> hit_idx) & NREG'(1)) != '0));

    // R10: a change flag implies the held mapping moved
    a_r10_flag_implies_move: assert property (@(posedge clk) disable iff (rst)
        (map_changed != '0) |->
            ((map_valid != $past(map_valid)) || (map_base != $past(map_base))));

    // R10: a moved mapping raises a change flag
    a_r10_move_implies_flag: assert property (@(posedge clk) disable iff (rst)
        ((map_valid != $past(map_valid)) || (map_base != $past(map_base))) |->
            (map_changed != '0));

    // R11: state is clear after a reset cycle
    a_r11_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (map_valid == '0 && map_base == '0 &&
                        map_changed == '0 && !hit_valid));

endmodule

bind bar_window_decoder bar_window_decoder_chk #(.NUM_BARS(NUM_BARS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_reg     (cmd_reg),
    .bar_is_io   (bar_is_io),
    .rom_raw     (rom_raw),
    .txn_valid   (txn_valid),
    .map_valid   (map_valid),
    .map_base    (map_base),
    .map_changed (map_changed),
    .hit_valid   (hit_valid),
    .hit_idx     (hit_idx)
);

// File: tb/tb_bar_window_decoder.sv
module tb_bar_window_decoder;

    localparam int NB    = 6;
    localparam int NREG  = NB + 1;
    localparam int IDX_W = $clog2(NREG);
    localparam int ROM   = NB;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [15:0]          cmd_reg = '0;
    logic [NB*32-1:0]     bar_raw = '0;
    logic [NB*32-1:0]     bar_size = '0;
    logic [NB-1:0]        bar_is_io = '0;
    logic [31:0]          rom_raw = '0;
    logic [31:0]          rom_size = '0;
    logic                 txn_valid = 1'b0;
    logic                 txn_is_io = 1'b0;
    logic [31:0]          txn_addr = '0;
    logic [NREG-1:0]      map_valid;
    logic [NREG*32-1:0]   map_base;
    logic [NREG-1:0]      map_changed;
    logic                 hit_valid;
    logic [IDX_W-1:0]     hit_idx;

    bar_window_decoder #(.NUM_BARS(NB)) dut (
        .clk, .rst, .cmd_reg, .bar_raw, .bar_size, .bar_is_io,
        .rom_raw, .rom_size, .txn_valid, .txn_is_io, .txn_addr,
        .map_valid, .map_base, .map_changed, .hit_valid, .hit_idx
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int          due;
        int          sel;    // 0 claim, 1 mapped flags, 2 change flags, 3 base
        int          ridx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t queue_q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_at(int dly, int sel, int ridx, logic [31:0] exp, string req);
        item_t it;
        it.due = cyc + dly; it.sel = sel; it.ridx = ridx; it.exp = exp; it.req = req;
        queue_q.push_back(it);
    endtask

    // monitor: pops expectations whose cycle has come
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (queue_q.size() > 0 && queue_q[0].due <= cyc) begin
                item_t it;
                it = queue_q.pop_front();
                case (it.sel)
                    0: compare(it.req, "claim", {28'd0, hit_valid, hit_idx}, it.exp);
                    1: compare(it.req, "mapped", 32'(map_valid), it.exp);
                    2: compare(it.req, "changed", 32'(map_changed), it.exp);
                    default: compare(it.req, "base", map_base[it.ridx*32 +: 32], it.exp);
                endcase
            end
        end
    end

    function automatic logic [31:0] claim(bit hit, int idx);
        return hit ? (32'd8 | 32'(idx)) : 32'd0;
    endfunction

    task automatic set_bar(int i, logic [31:0] raw, logic [31:0] size, bit io);
        bar_raw[i*32 +: 32]  = raw;
        bar_size[i*32 +: 32] = size;
        bar_is_io[i]         = io;
    endtask

    // apply already staged settings and expect the new mapping
    task automatic commit(logic [6:0] exp_valid, logic [6:0] exp_chg, string req);
        expect_at(1, 1, 0, 32'(exp_valid), req);
        expect_at(1, 2, 0, 32'(exp_chg), req);
        expect_at(2, 2, 0, 32'd0, "R10");
    endtask

    task automatic txn(bit io, logic [31:0] a, bit hit, int idx, string req);
        @(negedge clk);
        txn_valid = 1'b1;
        txn_is_io = io;
        txn_addr  = a;
        expect_at(1, 0, 0, claim(hit, idx), req);
    endtask

    task automatic idle();
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    bit done = 0;

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_cmp++; n_bad++;
                    $display("FAIL watchdog: actual running expected finished");
                end
            end
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                compare("R11", "mapped", 32'(map_valid), 32'd0);
                compare("R11", "changed", 32'(map_changed), 32'd0);
                compare("R11", "claim", {28'd0, hit_valid, hit_idx}, 32'd0);

                // step 1: both spaces on, mixed regions
                @(negedge clk);
                cmd_reg = 16'h0003;
                set_bar(0, 32'h0000_1001, 32'h100,      1'b1); // io 1000..10FF
                set_bar(1, 32'h8000_0000, 32'h1000,     1'b0); // mem 80000000..80000FFF
                set_bar(2, 32'h8000_0123, 32'h0100_0000, 1'b0); // mem overlaps region 1
                set_bar(3, 32'hFFFF_F000, 32'h1000,     1'b0); // end all-ones
                set_bar(4, 32'h0000_FF00, 32'h100,      1'b1); // io ends at FFFF
                set_bar(5, 32'h0001_0000, 32'h100,      1'b1); // io past ceiling
                rom_raw  = 32'h000C_0001;
                rom_size = 32'h0001_0000;
                commit(7'h57, 7'h57, "R9");
                expect_at(1, 3, 0, 32'h0000_1000, "R3");
                expect_at(1, 3, 2, 32'h8000_0000, "R3");
                expect_at(1, 3, 3, 32'h0, "R5");
                expect_at(1, 3, 5, 32'h0, "R4");
                txn(1'b1, 32'h0000_1000, 1'b1, 0, "R7");
                txn(1'b1, 32'h0000_10FF, 1'b1, 0, "R7");
                txn(1'b1, 32'h0000_1100, 1'b0, 0, "R7");
                txn(1'b0, 32'h0000_1000, 1'b0, 0, "R7");
                txn(1'b0, 32'h8000_0800, 1'b1, 1, "R8");
                txn(1'b0, 32'h8000_1000, 1'b1, 2, "R3");
                txn(1'b0, 32'hFFFF_F800, 1'b0, 0, "R5");
                txn(1'b1, 32'h0000_FF80, 1'b1, 4, "R4");
                txn(1'b1, 32'h0001_0000, 1'b0, 0, "R4");
                txn(1'b0, 32'h000C_1234, 1'b1, ROM, "R2");
                idle();

                // step 2: I/O space disabled
                cmd_reg = 16'h0002;
                commit(7'h46, 7'h11, "R1");
                txn(1'b1, 32'h0000_1000, 1'b0, 0, "R1");
                idle();

                // step 3: ROM enable bit cleared
                rom_raw = 32'h000C_0000;
                commit(7'h06, 7'h40, "R2");
                txn(1'b0, 32'h000C_1234, 1'b0, 0, "R2");
                idle();

                // step 4: region 1 sized zero, region 2 now claims
                set_bar(1, 32'h8000_0000, 32'h0, 1'b0);
                commit(7'h04, 7'h02, "R6");
                txn(1'b0, 32'h8000_0800, 1'b1, 2, "R6");
                idle();

                // step 5: region 2 base masks to zero
                set_bar(2, 32'h0000_0010, 32'h1000, 1'b0);
                commit(7'h00, 7'h04, "R5");
                txn(1'b0, 32'h0000_0010, 1'b0, 0, "R5");
                idle();

                // step 6: I/O back on, region 5 size one (end not above base)
                cmd_reg = 16'h0003;
                set_bar(5, 32'h0000_2000, 32'h1, 1'b1);
                commit(7'h11, 7'h11, "R4");
                txn(1'b1, 32'h0000_2000, 1'b0, 0, "R4");
                idle();

                // step 7: only the base of region 0 moves
                set_bar(0, 32'h0000_3000, 32'h100, 1'b1);
                commit(7'h11, 7'h01, "R10");
                expect_at(1, 3, 0, 32'h0000_3000, "R10");
                txn(1'b1, 32'h0000_3010, 1'b1, 0, "R7");
                idle();

                // step 8: overlapping I/O windows, lower index wins
                set_bar(4, 32'h0000_3000, 32'h1000, 1'b1);
                commit(7'h11, 7'h10, "R8");
                txn(1'b1, 32'h0000_30F0, 1'b1, 0, "R8");
                txn(1'b1, 32'h0000_3100, 1'b1, 4, "R8");
                idle();

                repeat (4) @(negedge clk);
                if (queue_q.size() != 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: actual %0d pending expected 0", queue_q.size());
                end
                done = 1;
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule